// File: doc/BRIEF.md
# Programmable Phase-Skew Clock Output Pair

This block produces one pair of identical clock outputs from a fast sampling clock that runs at sixteen times the nominal output rate. One skew unit is therefore one sampling period, and one output period is sixteen units. Three select inputs each carry a three-level value (LOW, MID or HIGH). Together they choose a phase offset of up to seven units either way, an inverted output, division by two or four, or a static disable. The select inputs are meant to be tied off.

An edge-select input chooses which half of the period the outputs align to, and it also sets the parking level. A stop request parks the outputs at that level. Entry into the parked state and exit from it happen only while the waveform is already at the parking level, so no short pulse can reach the clock tree. A build option marks the pair as the loop-feedback pair, which ignores the stop request. A bypass input swaps the internal waveform for a sampled copy of an external reference clock. The programmed skew still applies to that copy as a delay.

Top module: `skew_clk_pair`

## Requirements
- R1: Each select input is a 2-bit code: 2'b00 is LOW, 2'b10 is HIGH, 2'b01 is MID, and 2'b11 (undriven) is also taken as MID. The all-MID setting gives zero skew.
- R2: Read the select digits (d2,d1,d0) as a base-3 number N, with LOW=0, MID=1 and HIGH=2. Values N=6 to 20 select skew s=N-13. Let n count rising clock edges after reset release, with the first such edge being n=1, and let p=(n-1) mod 16. With bypass low and edge select high, the level of the next output after edge n is HIGH exactly when (p-s) mod 16 < 8.
- R3: Code (H,M,L) gives the complement of the zero-skew waveform of R2.
- R4: Code (H,M,M) gives HIGH when floor((n-1)/16) is even. Code (H,M,H) gives HIGH when floor((n-1)/32) is even.
- R5: Code (L,L,L) holds the outputs static at the parking level.
- R6: Reserved codes (N = 1 to 5 and 24 to 26) act as zero skew. Applying one sets the rsvd_seen flag on the next edge. The flag stays set until reset.
- R7: With edge select low, every waveform of R2 to R4 and R10 is inverted. The parking level is always the complement of edge select.
- R8: While stop_req is high, a non-feedback pair parks at the parking level. The run state changes only on edges where the selected level already equals the parking level. As a result, no pulse away from the parking level is shorter than the waveform's own.
- R9: A pair built as the feedback pair ignores stop_req.
- R10: With bypass high, the level after edge n equals ref_i as sampled at edge n-8-s. The value is 0 when that edge is not after reset release. Divide codes use s=0. Invert complements the sampled value. Disable stays static.
- R11: Reset is synchronous. While reset is held, the outputs sit at the parking level and rsvd_seen is low. After release the run state starts parked, so the outputs stay at the parking level until the waveform first reaches it.
- R12: All outputs of the pair carry the same value on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, 16 times the nominal output rate |
| rst | input | 1 | Synchronous reset, active high |
| ref_i | input | 1 | Reference clock, sampled for bypass mode |
| code_d2 | input | 2 | Most significant three-level select digit |
| code_d1 | input | 2 | Middle three-level select digit |
| code_d0 | input | 2 | Least significant three-level select digit |
| stop_req | input | 1 | Synchronous stop request, active high |
| rise_align | input | 1 | Edge select: high aligns to the rising edge, low to the falling edge |
| bypass | input | 1 | Routes the sampled reference to the outputs |
| clk_o | output | PAIR_W | The output pair |
| rsvd_seen | output | 1 | Sticky flag: a reserved select code was applied |

## Verification
The hardest situation to reach is a stop request that arrives in the middle of a pulse, and a release that arrives in the middle of a parked low phase. In both cases the output must keep its level until the waveform itself reaches the parking level. The bench reaches this by raising and dropping stop_req at phases chosen away from the waveform's own transitions, and by toggling stop_req every few cycles on a skewed, falling-aligned setting. It measures every run length on the output, and it runs a feedback-built copy on the same inputs. Bypass delays are reached by sweeping all select codes against a reference pattern that is irregular, so that each tap gives a distinct sequence.

// File: rtl/skew_pair_pkg.sv
package skew_pair_pkg;

   typedef enum logic [2:0] {
      MD_SKEW = 3'd0,
      MD_INV  = 3'd1,
      MD_DIV2 = 3'd2,
      MD_DIV4 = 3'd3,
      MD_OFF  = 3'd4
   } pair_mode_e;

   localparam int SKEW_MAX = 7;
   localparam int SKEW_W   = 4;

   localparam logic [1:0] ENC_LO = 2'b00;
   localparam logic [1:0] ENC_HI = 2'b10;

   // three-level digit value; 01 and the undriven 11 both count as MID
   function automatic int digit_val(input logic [1:0] enc);
      if (enc == ENC_LO)      return 0;
      else if (enc == ENC_HI) return 2;
      else                    return 1;
   endfunction

endpackage

// File: rtl/skew_sel_decode.sv
module skew_sel_decode
   import skew_pair_pkg::*;
(
   input  logic [1:0]               d2_i,
   input  logic [1:0]               d1_i,
   input  logic [1:0]               d0_i,
   output pair_mode_e               mode_o,
   output logic signed [SKEW_W-1:0] skew_o,
   output logic                     rsvd_o
);

   localparam int IDX_OFF  = 0;
   localparam int IDX_TLO  = 6;
   localparam int IDX_ZERO = 13;
   localparam int IDX_THI  = 20;
   localparam int IDX_INV  = 21;
   localparam int IDX_DIV2 = 22;
   localparam int IDX_DIV4 = 23;

   int code_idx;

   always_comb begin
      code_idx = 9 * digit_val(d2_i) + 3 * digit_val(d1_i) + digit_val(d0_i);
      mode_o   = MD_SKEW;
      skew_o   = '0;
      rsvd_o   = 1'b0;
      if (code_idx == IDX_OFF) begin
         mode_o = MD_OFF;
      end else if (code_idx >= IDX_TLO && code_idx <= IDX_THI) begin
         skew_o = SKEW_W'(code_idx - IDX_ZERO);
      end else if (code_idx == IDX_INV) begin
         mode_o = MD_INV;
      end else if (code_idx == IDX_DIV2) begin
         mode_o = MD_DIV2;
      end else if (code_idx == IDX_DIV4) begin
         mode_o = MD_DIV4;
      end else begin
         rsvd_o = 1'b1;
      end
   end

endmodule

// File: rtl/skew_phase_gen.sv
module skew_phase_gen #(
   parameter int PH_W  = 4,
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   output logic [PH_W-1:0]  ph_o,
   output logic [DIV_W-1:0] div_o
);

   generate
      if (PH_W < 1) begin : g_bad_ph
         $error("skew_phase_gen: PH_W must be positive");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("skew_phase_gen: DIV_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_o  <= '0;
         div_o <= '0;
      end else begin
         ph_o <= ph_o + 1'b1;
         if (ph_o == '1) begin
            div_o <= div_o + 1'b1;
         end
      end
   end

endmodule

// File: rtl/skew_ref_delay.sv
module skew_ref_delay #(
   parameter int DEPTH = 15,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ref_i,
   input  logic [IDX_W-1:0] tap_i,
   output logic             tap_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("skew_ref_delay: DEPTH must be at least 2");
      end
      if ((1 << IDX_W) < DEPTH) begin : g_bad_idx
         $error("skew_ref_delay: IDX_W too narrow for DEPTH");
      end
   endgenerate

   logic [DEPTH-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (rst) hist_q <= '0;
      else     hist_q <= {hist_q[DEPTH-2:0], ref_i};
   end

   always_comb begin
      tap_o = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         if (tap_i == IDX_W'(i)) tap_o = hist_q[i];
      end
   end

endmodule

// File: rtl/skew_gate_ctrl.sv
module skew_gate_ctrl #(
   parameter int PAIR_W      = 2,
   parameter bit IGNORE_STOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lvl_i,
   input  logic              park_i,
   input  logic              stop_req_i,
   output logic              run_q,
   output logic [PAIR_W-1:0] out_q
);

   logic want_run;
   logic run_nxt;

   generate
      if (IGNORE_STOP) begin : g_fb
         assign want_run = 1'b1;
      end else begin : g_gated
         assign want_run = ~stop_req_i;
      end
   endgenerate

   // the run state may only change while the waveform sits at the parking level
   assign run_nxt = (lvl_i == park_i) ? want_run : run_q;

   always_ff @(posedge clk) begin
      if (rst) run_q <= 1'b0;
      else     run_q <= run_nxt;
   end

   generate
      for (genvar g = 0; g < PAIR_W; g++) begin : g_out
         always_ff @(posedge clk) begin
            if (rst) out_q[g] <= park_i;
            else     out_q[g] <= run_nxt ? lvl_i : park_i;
         end
      end
   endgenerate

endmodule

// File: rtl/skew_clk_pair.sv
module skew_clk_pair
   import skew_pair_pkg::*;
#(
   parameter int PH_W          = 4,
   parameter int PAIR_W        = 2,
   parameter bit FEEDBACK_PAIR = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ref_i,
   input  logic [1:0]        code_d2,
   input  logic [1:0]        code_d1,
   input  logic [1:0]        code_d0,
   input  logic              stop_req,
   input  logic              rise_align,
   input  logic              bypass,
   output logic [PAIR_W-1:0] clk_o,
   output logic              rsvd_seen
);

   localparam int UNITS     = 1 << PH_W;
   localparam int DIV_W     = 2;
   localparam int DLY_DEPTH = 2 * SKEW_MAX + 1;
   localparam int TAP_W     = $clog2(DLY_DEPTH);
   localparam logic [PH_W-1:0] HALF_P = PH_W'(UNITS / 2);

   generate
      if (PH_W < 4) begin : g_bad_ph
         $error("skew_clk_pair: PH_W below 4 cannot hold +/-7 units");
      end
      if (PAIR_W < 1) begin : g_bad_pair
         $error("skew_clk_pair: PAIR_W must be positive");
      end
   endgenerate

   pair_mode_e               mode_w;
   logic signed [SKEW_W-1:0] skew_w;
   logic                     rsvd_w;
   logic [PH_W-1:0]          ph_w;
   logic [DIV_W-1:0]         div_w;
   logic [PH_W-1:0]          shifted_ph;
   logic [TAP_W-1:0]         tap_idx;
   logic                     ref_tap;
   logic                     raw_lvl;
   logic                     sel_lvl;
   logic                     park_lvl;
   logic                     run_q;

   skew_sel_decode dec_i (
      .d2_i   (code_d2),
      .d1_i   (code_d1),
      .d0_i   (code_d0),
      .mode_o (mode_w),
      .skew_o (skew_w),
      .rsvd_o (rsvd_w)
   );

   skew_phase_gen #(.PH_W(PH_W), .DIV_W(DIV_W)) phase_i (
      .clk   (clk),
      .rst   (rst),
      .ph_o  (ph_w),
      .div_o (div_w)
   );

   assign tap_idx = TAP_W'(int'(skew_w) + SKEW_MAX);

   skew_ref_delay #(.DEPTH(DLY_DEPTH), .IDX_W(TAP_W)) dly_i (
      .clk   (clk),
      .rst   (rst),
      .ref_i (ref_i),
      .tap_i (tap_idx),
      .tap_o (ref_tap)
   );

   assign shifted_ph = PH_W'(int'(ph_w) - int'(skew_w) + UNITS);
   assign park_lvl   = ~rise_align;

   always_comb begin
      unique case (mode_w)
         MD_SKEW: raw_lvl = bypass ? ref_tap  : (shifted_ph < HALF_P);
         MD_INV:  raw_lvl = bypass ? ~ref_tap : ~(ph_w < HALF_P);
         MD_DIV2: raw_lvl = bypass ? ref_tap  : ~div_w[0];
         MD_DIV4: raw_lvl = bypass ? ref_tap  : ~div_w[1];
         default: raw_lvl = 1'b0;
      endcase
   end

   assign sel_lvl = (mode_w == MD_OFF) ? park_lvl
                  : (rise_align ? raw_lvl : ~raw_lvl);

   skew_gate_ctrl #(.PAIR_W(PAIR_W), .IGNORE_STOP(FEEDBACK_PAIR)) gate_i (
      .clk        (clk),
      .rst        (rst),
      .lvl_i      (sel_lvl),
      .park_i     (park_lvl),
      .stop_req_i (stop_req),
      .run_q      (run_q),
      .out_q      (clk_o)
   );

   always_ff @(posedge clk) begin
      if (rst)         rsvd_seen <= 1'b0;
      else if (rsvd_w) rsvd_seen <= 1'b1;
   end

endmodule

// File: rtl/skew_clk_pair_chk.sv
module skew_clk_pair_chk
   import skew_pair_pkg::*;
#(
   parameter int PAIR_W = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              rise_align,
   input logic [PAIR_W-1:0] clk_o,
   input logic              rsvd_seen,
   input pair_mode_e        mode_w,
   input logic              run_q
);

   // R11
   reset_park_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> clk_o == {PAIR_W{~$past(rise_align)}});

   // R5
   off_static_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(mode_w) == MD_OFF) |-> clk_o == {PAIR_W{~$past(rise_align)}});

   // R8
   parked_level_chk: assert property (@(posedge clk) disable iff (rst)
      !run_q |-> clk_o == {PAIR_W{~$past(rise_align)}});

   // R6
   rsvd_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rsvd_seen) |-> rsvd_seen);

   // R12
   pair_equal_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(clk_o) == 0) || ($countones(clk_o) == PAIR_W));

endmodule

bind skew_clk_pair skew_clk_pair_chk #(.PAIR_W(PAIR_W)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .rise_align (rise_align),
   .clk_o      (clk_o),
   .rsvd_seen  (rsvd_seen),
   .mode_w     (mode_w),
   .run_q      (run_q)
);

// File: tb/skew_clk_pair_tb_top.sv
`timescale 1ns/1ps
module skew_clk_pair_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ref_i = 1'b0;
   logic [1:0] code_d2 = 2'b01;
   logic [1:0] code_d1 = 2'b01;
   logic [1:0] code_d0 = 2'b01;
   logic       stop_req = 1'b0;
   logic       rise_align = 1'b1;
   logic       bypass = 1'b0;
   logic [1:0] q_d, q_f;
   logic       rs_d, rs_f;

   always #5 clk = ~clk;

   skew_clk_pair #(.PH_W(4), .PAIR_W(2), .FEEDBACK_PAIR(1'b0)) dut_i (
      .clk(clk), .rst(rst), .ref_i(ref_i), .code_d2(code_d2), .code_d1(code_d1),
      .code_d0(code_d0), .stop_req(stop_req), .rise_align(rise_align),
      .bypass(bypass), .clk_o(q_d), .rsvd_seen(rs_d));

   skew_clk_pair #(.PH_W(4), .PAIR_W(2), .FEEDBACK_PAIR(1'b1)) fb_i (
      .clk(clk), .rst(rst), .ref_i(ref_i), .code_d2(code_d2), .code_d1(code_d1),
      .code_d0(code_d0), .stop_req(stop_req), .rise_align(rise_align),
      .bypass(bypass), .clk_o(q_f), .rsvd_seen(rs_f));

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 0;
   int  n;
   bit  refh [0:4095];
   bit  open_d, open_f;
   int  cfg_md, cfg_s;
   bit  cfg_rsv;
   bit  mis_d, mis_f;
   int  mis_n, mis_act, mis_exp;
   bit  watch, seen_edge, last_q;
   int  run_len, min_run;
   bit  ref_auto;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // mode codes: 0 skew, 1 invert, 2 divide by 2, 3 divide by 4, 4 disabled
   function automatic int dig(input logic [1:0] e);
      return (e == 2'b00) ? 0 : ((e == 2'b10) ? 2 : 1);
   endfunction

   task automatic decode_model(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c);
      int t;
      t = dig(a) * 100 + dig(b) * 10 + dig(c);
      cfg_md = 0; cfg_s = 0; cfg_rsv = 0;
      case (t)
         0:   cfg_md = 4;
         111: cfg_s = 0;
         20:  cfg_s = -7;
         21:  cfg_s = -6;
         22:  cfg_s = -5;
         100: cfg_s = -4;
         101: cfg_s = -3;
         102: cfg_s = -2;
         110: cfg_s = -1;
         112: cfg_s = 1;
         120: cfg_s = 2;
         121: cfg_s = 3;
         122: cfg_s = 4;
         200: cfg_s = 5;
         201: cfg_s = 6;
         202: cfg_s = 7;
         210: cfg_md = 1;
         211: cfg_md = 2;
         212: cfg_md = 3;
         default: cfg_rsv = 1;
      endcase
   endtask

   function automatic bit ref_at(input int m);
      return (m < 1) ? 1'b0 : refh[m];
   endfunction

   function automatic bit model_lvl();
      int  p;
      bit  raw, park;
      p = (n - 1) % 16;
      park = ~rise_align;
      if (cfg_md == 4) return park;
      if (bypass) begin
         case (cfg_md)
            0:       raw = ref_at(n - 8 - cfg_s);
            1:       raw = ~ref_at(n - 8);
            default: raw = ref_at(n - 8);
         endcase
      end else begin
         case (cfg_md)
            0:       raw = (((p - cfg_s + 16) % 16) < 8);
            1:       raw = !(p < 8);
            2:       raw = (((n - 1) / 16) % 2) == 0;
            default: raw = (((n - 1) / 32) % 2) == 0;
         endcase
      end
      return rise_align ? raw : ~raw;
   endfunction

   task automatic tick();
      bit lvl, park, exp_d, exp_f;
      @(posedge clk);
      #1;
      n++;
      refh[n] = ref_i;
      park = ~rise_align;
      lvl = model_lvl();
      if (lvl == park) begin
         open_d = !stop_req;
         open_f = 1'b1;
      end
      exp_d = open_d ? lvl : park;
      exp_f = open_f ? lvl : park;
      if (q_d !== {2{exp_d}} && !mis_d) begin
         mis_d = 1; mis_n = n; mis_act = int'(q_d); mis_exp = exp_d ? 3 : 0;
      end
      if (q_f !== {2{exp_f}} && !mis_f) begin
         mis_f = 1;
         if (!mis_d) begin
            mis_n = n; mis_act = int'(q_f); mis_exp = exp_f ? 3 : 0;
         end
      end
      if (watch) begin
         if (q_d[0] != last_q) begin
            if (seen_edge && run_len < min_run) min_run = run_len;
            seen_edge = 1;
            run_len = 1;
         end else begin
            run_len++;
         end
         last_q = q_d[0];
      end
      if (ref_auto) ref_i = ((n / 3) % 2 == 1) ^ ((n / 7) % 2 == 1) ^ (n % 5 == 0);
   endtask

   task automatic start_cfg(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c,
                            input bit rise, input bit byp);
      code_d2 = a; code_d1 = b; code_d0 = c;
      rise_align = rise; bypass = byp; stop_req = 0;
      decode_model(a, b, c);
      rst = 1;
      repeat (2) @(posedge clk);
      #1;
      n = 0; open_d = 0; open_f = 0; mis_d = 0; mis_f = 0;
      ref_i = 0;
      rst = 0;
   endtask

   function automatic string mode_tag(input bit byp);
      string t;
      if (byp)             t = "R10";
      else if (cfg_rsv)    t = "R6";
      else if (cfg_md == 0) t = "R2";
      else if (cfg_md == 1) t = "R3";
      else if (cfg_md == 4) t = "R5";
      else                 t = "R4";
      if (!rise_align) t = {t, "/R7"};
      if (code_d2 == 2'b11 || code_d1 == 2'b11 || code_d0 == 2'b11) t = {t, "/R1"};
      return t;
   endfunction

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      ref_auto = 0; watch = 0;
      // R11: reset state, falling and rising alignment
      rise_align = 1;
      repeat (3) @(posedge clk);
      #1;
      check(q_d == 2'b00 && q_f == 2'b00, "R11", "reset level, rise aligned", int'(q_d), 0);
      check(rs_d == 0, "R11", "flag cleared by reset", int'(rs_d), 0);
      rise_align = 0;
      @(posedge clk); #1;
      check(q_d == 2'b11, "R11", "reset level, fall aligned", int'(q_d), 3);

      // R1: undriven digits give zero skew
      start_cfg(2'b11, 2'b11, 2'b11, 1, 0);
      repeat (48) tick();
      check(!mis_d && !mis_f, "R1", "undriven selects as zero skew", mis_act, mis_exp);

      // sweep of every select encoding and both alignments (R2..R7, R12)
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int r = 0; r < 2; r++) begin
                  start_cfg(2'(a), 2'(b), 2'(c), r[0], 0);
                  repeat (66) tick();
                  check(!mis_d && !mis_f, mode_tag(0),
                        $sformatf("waveform code %0d%0d%0d rise %0d at n=%0d", a, b, c, r, mis_n),
                        mis_act, mis_exp);
                  check(rs_d == cfg_rsv, "R6", $sformatf("flag code %0d%0d%0d", a, b, c),
                        int'(rs_d), int'(cfg_rsv));
               end

      // R6: flag stays set after the select returns to a defined code
      start_cfg(2'b00, 2'b00, 2'b10, 1, 0);
      repeat (2) tick();
      code_d2 = 2'b01; code_d1 = 2'b01; code_d0 = 2'b01;
      repeat (5) @(posedge clk);
      #1;
      check(rs_d == 1, "R6", "flag sticky", int'(rs_d), 1);

      // R10: bypass sweep with an irregular reference
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++) begin
               start_cfg(2'(a), 2'(b), 2'(c), (a + c) % 2 == 0, 1);
               ref_auto = 1;
               repeat (72) tick();
               ref_auto = 0;
               check(!mis_d && !mis_f, mode_tag(1),
                     $sformatf("bypass code %0d%0d%0d at n=%0d", a, b, c, mis_n),
                     mis_act, mis_exp);
            end

      // R8/R9: stop request landing mid-pulse and release mid-park
      start_cfg(2'b01, 2'b01, 2'b01, 1, 0);
      watch = 1; seen_edge = 0; run_len = 0; min_run = 1000; last_q = 0;
      repeat (37) tick();
      stop_req = 1;
      repeat (40) tick();
      check(q_d == 2'b00, "R8", "parked low while stopped", int'(q_d), 0);
      stop_req = 0;
      repeat (3) tick();
      check(q_d == 2'b00, "R8", "no early resume mid low phase", int'(q_d), 0);
      repeat (40) tick();
      check(!mis_d, "R8", $sformatf("gated sequence at n=%0d", mis_n), mis_act, mis_exp);
      check(!mis_f, "R9", $sformatf("feedback pair ignores stop at n=%0d", mis_n),
            mis_act, mis_exp);
      check(min_run >= 8, "R8", "shortest pulse", min_run, 8);
      watch = 0;

      // R8: fast toggling stop request on a skewed falling-aligned setting
      start_cfg(2'b01, 2'b10, 2'b01, 0, 0);
      watch = 1; seen_edge = 0; run_len = 0; min_run = 1000; last_q = 1;
      for (int k = 0; k < 30; k++) begin
         stop_req = (k % 3) != 0;
         repeat (5) tick();
      end
      check(!mis_d, "R8", $sformatf("toggled stop at n=%0d", mis_n), mis_act, mis_exp);
      check(!mis_f, "R9", "feedback pair under toggled stop", mis_act, mis_exp);
      check(min_run >= 8, "R8", "shortest pulse under toggled stop", min_run, 8);
      watch = 0;

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule